// File: doc/BRIEF.md
# Display Panel Power Sequencer

This block sits on the host side of a serial link to a small display panel controller. It accepts a request for a power state (on or off) and turns it into a timed sequence of register writes. It shifts these writes out as an SPI master in mode 0, sending the most significant bit first. Each register write takes two chip-select frames of three bytes each. The first frame carries the register index. The second frame carries the 16-bit value. Between groups of writes the block waits for fixed intervals of some milliseconds, timed by a prescaled counter.

The block holds the current panel power state and comes out of reset in the off state. A request starts a script only when it asks for the state the panel is not in. A power-on script first replays the complete power-off script and then runs its own steps. Only when the script finishes is the requested state adopted. While a script runs, `busy` is high and new requests are dropped. A one-cycle `done` pulse marks the end of each script.

Build-time parameters set the identifier bit placed in every start byte and an optional mode that complements each byte on the wire. They also set the system clock frequency, the serial clock ceiling and the number of clocks per millisecond.

Top module: `panel_power_seq`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `mosi` is 0, `busy` is 0, `done` is 0 and the stored power state is off.
- R2: While `cs_n` is low, every high phase and every low phase of `sck` lasts at least ceil(CLK_HZ / (2 * SCK_MAX_HZ)) clocks, so `sck` never exceeds SCK_MAX_HZ (4 MHz by default).
- R3: Each `cs_n` low period carries exactly 24 bits, MSB first. `sck` idles low, `mosi` changes only while `sck` is low, and the receiver samples on the rising edge. `cs_n` returns high between the index frame and the data frame of a write.
- R4: Index frame bytes are [start, 0x00, index]. Data frame bytes are [start, value[15:8], value[7:0]]. The start byte is 0b01110 in bits 7..3, DEV_ID in bit 2, a select bit in bit 1 (0 = index, 1 = data) and 0 in bit 0 (write).
- R5: The power-off script is, in order: 0x10 <- 0x0000, wait 10 ms, 0x11 <- 0x0000, 0x12 <- 0x0000, wait 40 ms, 0x13 <- 0x0000, wait 40 ms.
- R6: The power-on script is the complete power-off script, followed by 0x56 <- 0x080F, 0x10 <- 0x4240, wait 10 ms, 0x11 <- 0x0000, 0x12 <- 0x0014, wait 40 ms, 0x13 <- 0x1319, wait 40 ms.
- R7: A wait of N ms keeps the link idle for at least N * TICKS_PER_MS clocks. This is measured from the `cs_n` rise that ends the preceding write to the next `cs_n` fall, or to `done` after the final wait.
- R8: An on request while off starts the power-on script, and an off request while on starts the power-off script. Any other request produces no frame and leaves `busy` low.
- R9: The stored power state takes the requested value only when its script has completed. Later requests are judged against this updated state.
- R10: `busy` rises in the clock after an accepted request and stays high up to and including the `done` cycle. Any request sampled while `busy` is high is ignored.
- R11: `done` is high for exactly one clock at the end of each script.
- R12: With INVERT_TX set, every byte of every frame is sent bitwise complemented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-clock strobe presenting a power request |
| req_on | input | 1 | Requested state: 1 = on, 0 = off |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the panel |
| cs_n | output | 1 | Active-low chip select, one low period per frame |
| busy | output | 1 | High while a script is running |
| done | output | 1 | One-clock pulse when a script finishes |

## Verification
The end-of-script `done` pulse and the acceptance of a fresh request can fall in the same clock. The final wait of a script expires and `done` rises in the same clock where a new request might be sampled. To provoke this, the bench watches for `done` during a power-off run and drives an on request in exactly that clock. It then judges that the request was dropped: `busy` stays low and no frame appears. It also checks that the next on request runs the full power-on script, which shows that the off state was committed despite the collision. A request is also injected mid-script to confirm that it neither aborts nor extends the running sequence.

// File: rtl/pps_pkg.sv
package pps_pkg;

    typedef struct packed {
        logic        is_wait;
        logic [7:0]  ms;
        logic [7:0]  idx;
        logic [15:0] val;
    } step_t;

    localparam int STEP_W   = 4;
    localparam int OFF_LAST = 6;
    localparam int ON_LAST  = 14;

    function automatic step_t wr(input logic [7:0] idx, input logic [15:0] val);
        step_t s;
        s.is_wait = 1'b0;
        s.ms      = 8'd0;
        s.idx     = idx;
        s.val     = val;
        return s;
    endfunction

    function automatic step_t dly(input logic [7:0] ms);
        step_t s;
        s.is_wait = 1'b1;
        s.ms      = ms;
        s.idx     = 8'h00;
        s.val     = 16'h0000;
        return s;
    endfunction

    // Steps 0..OFF_LAST form the shut-down part; the power-up script
    // continues through ON_LAST.
    function automatic step_t script_step(input logic [STEP_W-1:0] n);
        case (n)
            4'd0:    return wr(8'h10, 16'h0000);
            4'd1:    return dly(8'd10);
            4'd2:    return wr(8'h11, 16'h0000);
            4'd3:    return wr(8'h12, 16'h0000);
            4'd4:    return dly(8'd40);
            4'd5:    return wr(8'h13, 16'h0000);
            4'd6:    return dly(8'd40);
            4'd7:    return wr(8'h56, 16'h080F);
            4'd8:    return wr(8'h10, 16'h4240);
            4'd9:    return dly(8'd10);
            4'd10:   return wr(8'h11, 16'h0000);
            4'd11:   return wr(8'h12, 16'h0014);
            4'd12:   return dly(8'd40);
            4'd13:   return wr(8'h13, 16'h1319);
            default: return dly(8'd40);
        endcase
    endfunction

    function automatic logic [7:0] start_byte(input logic id, input logic sel);
        return {5'b01110, id, sel, 1'b0};
    endfunction

endpackage

// File: rtl/pps_spi_frame.sv
module pps_spi_frame #(
    parameter int HALF   = 13,
    parameter bit INVERT = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [23:0] word,
    output logic        sck,
    output logic        mosi,
    output logic        cs_n,
    output logic        frame_done
);
    localparam int DIV_W = $clog2(HALF + 1);
    localparam int BIT_W = 5;

    typedef enum logic [1:0] {F_IDLE, F_SHIFT, F_GAP} fst_e;

    typedef struct packed {
        fst_e             st;
        logic [23:0]      sh;
        logic [BIT_W-1:0] bit_n;
        logic [DIV_W-1:0] div;
        logic             sck;
        logic             cs_n;
        logic             done;
    } fr_t;

    fr_t         q, d;
    logic [23:0] load_word;

    generate
        if (INVERT) begin : g_inv
            assign load_word = ~word;
        end else begin : g_pass
            assign load_word = word;
        end
    endgenerate

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            F_IDLE: begin
                if (start) begin
                    d.st    = F_SHIFT;
                    d.sh    = load_word;
                    d.bit_n = '0;
                    d.div   = '0;
                    d.sck   = 1'b0;
                    d.cs_n  = 1'b0;
                end
            end
            F_SHIFT: begin
                if (q.div == DIV_W'(HALF - 1)) begin
                    d.div = '0;
                    if (!q.sck) begin
                        d.sck = 1'b1;
                    end else begin
                        d.sck = 1'b0;
                        if (q.bit_n == BIT_W'(23)) begin
                            d.st = F_GAP;
                        end else begin
                            d.bit_n = q.bit_n + 1'b1;
                            d.sh    = {q.sh[22:0], 1'b0};
                        end
                    end
                end else begin
                    d.div = q.div + 1'b1;
                end
            end
            F_GAP: begin
                if (q.div == DIV_W'(HALF - 1)) begin
                    d.div = '0;
                    if (!q.cs_n) begin
                        d.cs_n = 1'b1;
                    end else begin
                        d.st   = F_IDLE;
                        d.done = 1'b1;
                    end
                end else begin
                    d.div = q.div + 1'b1;
                end
            end
            default: d.st = F_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= F_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sck        = q.sck;
    assign cs_n       = q.cs_n;
    assign mosi       = q.cs_n ? 1'b0 : q.sh[23];
    assign frame_done = q.done;

    // Cycles since the last serial clock toggle, for the rate check.
    logic [7:0] ph_cnt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_cnt_q <= '0;
        end else if (q.sck != d.sck) begin
            ph_cnt_q <= '0;
        end else if (ph_cnt_q != 8'hFF) begin
            ph_cnt_q <= ph_cnt_q + 1'b1;
        end
    end

    a_r2_min_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (sck != $past(sck)) |-> ($past(ph_cnt_q) >= 8'(HALF - 1)));

    a_r3_idle_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    a_r3_mosi_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    a_r3_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> cs_n);

endmodule

// File: rtl/pps_ms_timer.sv
module pps_ms_timer #(
    parameter int TICKS_PER_MS = 100000,
    parameter int MS_W         = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [MS_W-1:0] ms,
    output logic            expired
);
    localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;

    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] pre;
        logic [MS_W-1:0]  left;
        logic             fire;
    } tm_t;

    tm_t q, d;

    always_comb begin
        d      = q;
        d.fire = 1'b0;
        if (start) begin
            d.run  = 1'b1;
            d.pre  = '0;
            d.left = ms;
        end else if (q.run) begin
            if (q.pre == PRE_W'(TICKS_PER_MS - 1)) begin
                d.pre = '0;
                if (q.left <= MS_W'(1)) begin
                    d.run  = 1'b0;
                    d.fire = 1'b1;
                end else begin
                    d.left = q.left - 1'b1;
                end
            end else begin
                d.pre = q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign expired = q.fire;

    a_r7_start_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.run);

    a_r7_fire_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        expired |-> !q.run);

endmodule

// File: rtl/panel_power_seq.sv
module panel_power_seq #(
    parameter int CLK_HZ       = 100_000_000,
    parameter int SCK_MAX_HZ   = 4_000_000,
    parameter int TICKS_PER_MS = CLK_HZ / 1000,
    parameter bit DEV_ID       = 1'b1,
    parameter bit INVERT_TX    = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid,
    input  logic req_on,
    output logic sck,
    output logic mosi,
    output logic cs_n,
    output logic busy,
    output logic done
);
    import pps_pkg::*;

    localparam int HALF = (CLK_HZ + 2 * SCK_MAX_HZ - 1) / (2 * SCK_MAX_HZ);
    localparam int MS_W = 8;

    typedef enum logic [2:0] {
        P_IDLE, P_LOAD, P_IDX, P_DATA, P_WAIT, P_NEXT, P_FINISH
    } pst_e;

    typedef struct packed {
        pst_e              st;
        logic [STEP_W-1:0] step;
        logic [STEP_W-1:0] last;
        logic              target;
        logic              on;
        logic              fr_start;
        logic [23:0]       word;
        logic              tmr_start;
        logic [MS_W-1:0]   ms;
    } ctl_t;

    ctl_t  q, d;
    step_t cur;
    logic  fr_done;
    logic  tmr_expired;

    always_comb begin
        d           = q;
        d.fr_start  = 1'b0;
        d.tmr_start = 1'b0;
        cur         = script_step(q.step);
        case (q.st)
            P_IDLE: begin
                if (req_valid && (req_on != q.on)) begin
                    d.st     = P_LOAD;
                    d.step   = '0;
                    d.last   = req_on ? STEP_W'(ON_LAST) : STEP_W'(OFF_LAST);
                    d.target = req_on;
                end
            end
            P_LOAD: begin
                if (cur.is_wait) begin
                    d.tmr_start = 1'b1;
                    d.ms        = cur.ms;
                    d.st        = P_WAIT;
                end else begin
                    d.fr_start = 1'b1;
                    d.word     = {start_byte(DEV_ID, 1'b0), 8'h00, cur.idx};
                    d.st       = P_IDX;
                end
            end
            P_IDX: begin
                if (fr_done) begin
                    d.fr_start = 1'b1;
                    d.word     = {start_byte(DEV_ID, 1'b1), cur.val};
                    d.st       = P_DATA;
                end
            end
            P_DATA: begin
                if (fr_done) d.st = P_NEXT;
            end
            P_WAIT: begin
                if (tmr_expired) d.st = P_NEXT;
            end
            P_NEXT: begin
                if (q.step == q.last) begin
                    d.st = P_FINISH;
                end else begin
                    d.step = q.step + 1'b1;
                    d.st   = P_LOAD;
                end
            end
            P_FINISH: begin
                d.on = q.target;
                d.st = P_IDLE;
            end
            default: d.st = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= P_IDLE;
        end else begin
            q <= d;
        end
    end

    pps_spi_frame #(
        .HALF   (HALF),
        .INVERT (INVERT_TX)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (q.fr_start),
        .word       (q.word),
        .sck        (sck),
        .mosi       (mosi),
        .cs_n       (cs_n),
        .frame_done (fr_done)
    );

    pps_ms_timer #(
        .TICKS_PER_MS (TICKS_PER_MS),
        .MS_W         (MS_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (q.tmr_start),
        .ms      (q.ms),
        .expired (tmr_expired)
    );

    assign busy = (q.st != P_IDLE);
    assign done = (q.st == P_FINISH);

    a_r10_frame_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_same_state_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid && (req_on == q.on)) |=> !busy);

    a_r9_state_moves_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        (q.on != $past(q.on)) |-> $past(done));

    a_r10_no_restart_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.st != P_NEXT) |=> ($stable(q.step) || $past(q.st) == P_NEXT));

endmodule

// File: tb/panel_power_seq_tb.sv
module pps_frame_mon (
    input logic clk,
    input logic clear,
    input logic sck,
    input logic mosi,
    input logic cs_n,
    input logic done
);
    int          cyc = 0;
    int          n = 0;
    int          bits = 0;
    logic [23:0] shreg = '0;
    logic [23:0] frm [0:63];
    int          fbits [0:63];
    int          t_beg [0:63];
    int          t_end [0:63];
    int          done_t = 0;
    int          last_edge = 0;
    int          min_phase = 1000000;

    always @(negedge clk) cyc = cyc + 1;
    always @(posedge clear) begin
        n = 0;
        min_phase = 1000000;
    end
    always @(negedge cs_n) begin
        bits = 0;
        shreg = '0;
        if (n < 64) t_beg[n] = cyc;
    end
    always @(posedge sck) if (!cs_n) begin
        shreg = {shreg[22:0], mosi};
        bits = bits + 1;
    end
    always @(sck) begin
        if (!cs_n && (cyc - last_edge) < min_phase) min_phase = cyc - last_edge;
        last_edge = cyc;
    end
    always @(posedge cs_n) if (n < 64 && !clear) begin
        frm[n] = shreg;
        fbits[n] = bits;
        t_end[n] = cyc;
        n = n + 1;
    end
    always @(posedge done) done_t = cyc;
endmodule

module panel_power_seq_tb;
    localparam int CLK_HZ   = 100_000_000;
    localparam int SCK_MAX  = 4_000_000;
    localparam int TPM      = 20;
    localparam int HALF_EXP = (CLK_HZ + 2 * SCK_MAX - 1) / (2 * SCK_MAX);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_on = 1'b0;
    logic req_valid_i = 1'b0, req_on_i = 1'b0;
    logic clr = 1'b1, clr_i = 1'b1;
    logic sck, mosi, cs_n, busy, done;
    logic sck_i, mosi_i, cs_n_i, busy_i, done_i;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    panel_power_seq #(
        .CLK_HZ(CLK_HZ), .SCK_MAX_HZ(SCK_MAX), .TICKS_PER_MS(TPM),
        .DEV_ID(1'b1), .INVERT_TX(1'b0)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_on(req_on),
        .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy), .done(done)
    );

    panel_power_seq #(
        .CLK_HZ(CLK_HZ), .SCK_MAX_HZ(SCK_MAX), .TICKS_PER_MS(TPM),
        .DEV_ID(1'b0), .INVERT_TX(1'b1)
    ) u_dut_inv (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid_i), .req_on(req_on_i),
        .sck(sck_i), .mosi(mosi_i), .cs_n(cs_n_i), .busy(busy_i), .done(done_i)
    );

    pps_frame_mon mon     (.clk(clk), .clear(clr),   .sck(sck),   .mosi(mosi),   .cs_n(cs_n),   .done(done));
    pps_frame_mon mon_inv (.clk(clk), .clear(clr_i), .sck(sck_i), .mosi(mosi_i), .cs_n(cs_n_i), .done(done_i));

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Expected script: write w (0..8) of the power-up list; first 4 = shut-down.
    function automatic logic [7:0] w_idx(input int w);
        case (w)
            0: return 8'h10; 1: return 8'h11; 2: return 8'h12; 3: return 8'h13;
            4: return 8'h56; 5: return 8'h10; 6: return 8'h11; 7: return 8'h12;
            default: return 8'h13;
        endcase
    endfunction
    function automatic logic [15:0] w_val(input int w);
        case (w)
            4: return 16'h080F; 5: return 16'h4240; 7: return 16'h0014; 8: return 16'h1319;
            default: return 16'h0000;
        endcase
    endfunction
    function automatic int w_wait(input int w);
        case (w)
            0: return 10; 2: return 40; 3: return 40; 5: return 10; 7: return 40; 8: return 40;
            default: return 0;
        endcase
    endfunction
    function automatic logic [23:0] exp_frame(input int w, input bit data,
                                              input bit id, input bit inv);
        logic [7:0]  sb;
        logic [23:0] f;
        sb = {5'b01110, id, data, 1'b0};
        f  = data ? {sb, w_val(w)} : {sb, 8'h00, w_idx(w)};
        return inv ? ~f : f;
    endfunction

    task automatic pulse_req(input bit on);
        @(negedge clk);
        req_valid = 1'b1;
        req_on = on;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic clear_mon;
        @(negedge clk); clr = 1'b1; clr_i = 1'b1;
        @(negedge clk); clr = 1'b0; clr_i = 1'b0;
    endtask

    task automatic wait_done(input bit inv, input string req);
        int k;
        for (k = 0; k < 60000; k++) begin
            @(negedge clk);
            if ((inv ? done_i : done) == 1'b1) break;
        end
        chk(k < 60000, req, "done seen", k, 0);
        @(negedge clk);
        chk((inv ? done_i : done) == 1'b0, "R11", "done width", 1, 0);
        chk((inv ? busy_i : busy) == 1'b0, "R10", "busy drops after done", 1, 0);
    endtask

    // Compare n_writes writes against the script and check waits.
    task automatic check_script(input int n_writes, input bit inv, input bit id,
                                input string req);
        int n, dt;
        n = inv ? mon_inv.n : mon.n;
        chk(n == 2 * n_writes, req, "frame count", n, 2 * n_writes);
        for (int w = 0; w < n_writes; w++) begin
            for (int k = 0; k < 2; k++) begin
                int fi = 2 * w + k;
                logic [23:0] got;
                got = inv ? mon_inv.frm[fi] : mon.frm[fi];
                chk(got == exp_frame(w, k[0], id, inv), inv ? "R12" : "R4",
                    $sformatf("%s frame %0d", req, fi), got, exp_frame(w, k[0], id, inv));
                chk((inv ? mon_inv.fbits[fi] : mon.fbits[fi]) == 24, "R3", "bits per frame",
                    inv ? mon_inv.fbits[fi] : mon.fbits[fi], 24);
            end
            if (w_wait(w) != 0 && w != 3 + 5 * 0 || (w == 3 && n_writes == 4) || (w == 3)) begin
                if (w_wait(w) != 0) begin
                    if (w == n_writes - 1)
                        dt = (inv ? mon_inv.done_t : mon.done_t) - (inv ? mon_inv.t_end[2*w+1] : mon.t_end[2*w+1]);
                    else
                        dt = (inv ? mon_inv.t_beg[2*w+2] : mon.t_beg[2*w+2]) - (inv ? mon_inv.t_end[2*w+1] : mon.t_end[2*w+1]);
                    chk(dt >= w_wait(w) * TPM && dt <= w_wait(w) * TPM + HALF_EXP + 30, "R7",
                        $sformatf("wait after write %0d", w), dt, w_wait(w) * TPM);
                end
            end
        end
        chk((inv ? mon_inv.min_phase : mon.min_phase) >= HALF_EXP, "R2", "min sck phase",
            inv ? mon_inv.min_phase : mon.min_phase, HALF_EXP);
    endtask

    task automatic t_reset;
        chk(cs_n == 1'b1, "R1", "cs_n", cs_n, 1);
        chk(sck == 1'b0, "R1", "sck", sck, 0);
        chk(mosi == 1'b0, "R1", "mosi", mosi, 0);
        chk(busy == 1'b0, "R1", "busy", busy, 0);
        chk(done == 1'b0, "R1", "done", done, 0);
    endtask

    task automatic t_off_when_off;
        clear_mon();
        pulse_req(1'b0);
        chk(busy == 1'b0, "R8", "off while off busy", busy, 0);
        repeat (50) @(negedge clk);
        chk(mon.n == 0, "R8", "off while off frames", mon.n, 0);
        chk(busy == 1'b0, "R1", "initial state off", busy, 0);
    endtask

    task automatic t_power_on;
        clear_mon();
        pulse_req(1'b1);
        chk(busy == 1'b1, "R10", "busy after on request", busy, 1);
        repeat (200) @(negedge clk);
        pulse_req(1'b0);  // dropped: busy
        wait_done(1'b0, "R6");
        check_script(9, 1'b0, 1'b1, "R6");
    endtask

    task automatic t_on_when_on;
        clear_mon();
        pulse_req(1'b1);
        chk(busy == 1'b0, "R9", "on while on busy", busy, 0);
        repeat (50) @(negedge clk);
        chk(mon.n == 0, "R8", "on while on frames", mon.n, 0);
    endtask

    task automatic t_power_off_collide;
        int k;
        clear_mon();
        pulse_req(1'b0);
        chk(busy == 1'b1, "R9", "off runs after on committed", busy, 1);
        for (k = 0; k < 60000; k++) begin
            @(negedge clk);
            if (done) break;
        end
        chk(k < 60000, "R5", "off done seen", k, 0);
        req_valid = 1'b1;  // same clock as done
        req_on = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(done == 1'b0, "R11", "done width off", done, 0);
        chk(busy == 1'b0, "R10", "request at done ignored", busy, 0);
        repeat (40) @(negedge clk);
        chk(busy == 1'b0, "R10", "no script after collision", busy, 0);
        check_script(4, 1'b0, 1'b1, "R5");
        clear_mon();
        pulse_req(1'b1);
        chk(busy == 1'b1, "R9", "on runs after off committed", busy, 1);
        wait_done(1'b0, "R9");
        chk(mon.n == 18, "R9", "full on script frames", mon.n, 18);
    endtask

    task automatic t_invert;
        clear_mon();
        @(negedge clk);
        req_valid_i = 1'b1;
        req_on_i = 1'b1;
        @(negedge clk);
        req_valid_i = 1'b0;
        chk(busy_i == 1'b1, "R12", "inverted unit busy", busy_i, 1);
        wait_done(1'b1, "R12");
        check_script(9, 1'b1, 1'b0, "R12");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        clr = 1'b0; clr_i = 1'b0;
        @(negedge clk);
        t_reset();
        t_off_when_off();
        t_power_on();
        t_on_when_on();
        t_power_off_collide();
        t_invert();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule